// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit with Carry

This unit moves a W-bit operand (16 bits by default) one position left or right under a 3-bit operation code. It provides eight variants: plain shifts, a sign-keeping right shift, closed rotates, and rotates that pass through the carry flag. In every variant, the bit that leaves the operand is written to the carry. The two through-carry rotates take the incoming bit from the carry input, so the operand and the carry together form a W+1 bit ring.

The result and five condition flags are registered on the rising clock edge when `en` is high. The flags are carry, zero, sign, parity and overflow. Shifts refresh every flag. Rotates refresh only carry and overflow, and leave the registered zero, sign and parity flags as they were. The block is meant to sit behind an execution stage that supplies the current carry and takes the new flags back.

Top module: `shrot_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res` and all five flags become 0 at that edge.
- R2: Opcodes 3'b000 and 3'b001 both shift left: `res` = operand shifted left by one with 0 entering bit 0, and `cf` = the operand's old bit W-1.
- R3: Opcode 3'b010 shifts right: `res` = operand shifted right by one with 0 entering bit W-1, and `cf` = the operand's old bit 0.
- R4: Opcode 3'b011 shifts right while keeping the sign: bit W-1 of `res` equals the old bit W-1, `cf` = the old bit 0, and `ovf` = 0.
- R5: Opcode 3'b100 rotates left and 3'b101 rotates right. The bit leaving one end enters the other end and is also copied into `cf`.
- R6: Opcode 3'b110 rotates left through carry: `cin` enters bit 0 and the old bit W-1 goes to `cf`. Opcode 3'b111 rotates right through carry: `cin` enters bit W-1 and the old bit 0 goes to `cf`.
- R7: For opcodes 3'b000 to 3'b011, the flags are set from the new result: `zf` = 1 when `res` is zero, `sf` = bit W-1 of `res`, and `pf` = 1 when bits 7:0 of `res` hold an even number of ones.
- R8: For opcodes 3'b100 to 3'b111 (bit 2 set), `zf`, `sf` and `pf` keep their previous values.
- R9: `ovf` depends on the direction of the operation. After 3'b000, 3'b001, 3'b100 and 3'b110 it equals `res[W-1]` XOR the new `cf`. After 3'b010, 3'b101 and 3'b111 it equals `res[W-1]` XOR `res[W-2]`.
- R10: The outputs change only on the rising edge where `en` is high, and show the result of that edge's inputs. While `en` is low, every output holds, whatever `op`, `opnd` and `cin` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Register the result and flags at this edge |
| op | input | 3 | Operation code |
| opnd | input | W | Operand |
| cin | input | 1 | Current carry flag |
| res | output | W | Registered result |
| cf | output | 1 | Carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| pf | output | 1 | Parity flag (even count in low byte) |
| ovf | output | 1 | Overflow flag |

## Verification
Two things can happen in the same cycle in a through-carry rotate. The old carry enters the operand, and a new carry leaves it. The bench provokes this by running 3'b110 and 3'b111 with `cin` = 1 on operands whose outgoing bit is 0, and again where it is 1. A swapped or dropped carry path then shows up as a wrong end bit in `res` or a wrong `cf`. The second case is a rotate that directly follows a shift that set `zf`, `sf` or `pf`. Here the retained flags must come from the earlier shift, while `cf` and `ovf` come from the rotate. The reference model in the scoreboard holds its own copy of the retained flags and judges both at once.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int PAR_BITS = 8;

    typedef enum logic [2:0] {
        OP_SHL = 3'b000,
        OP_SAL = 3'b001,
        OP_SHR = 3'b010,
        OP_SAR = 3'b011,
        OP_ROL = 3'b100,
        OP_ROR = 3'b101,
        OP_RCL = 3'b110,
        OP_RCR = 3'b111
    } shift_op_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic pf;
        logic ovf;
    } flags_t;

    // Rotate family: bit 2 of the code set
    function automatic logic is_rotate(input shift_op_e op);
        return op[2];
    endfunction

    function automatic logic is_left(input shift_op_e op);
        return (op == OP_SHL) || (op == OP_SAL) || (op == OP_ROL) || (op == OP_RCL);
    endfunction

    // 1 when the byte holds an even number of ones
    function automatic logic even_parity(input logic [PAR_BITS-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_op_e      op,
    input  logic [W-1:0]   opnd,
    input  logic           cin,
    output logic [W-1:0]   res_next,
    output logic           cout
);
    localparam int MSB = W - 1;

    logic left;
    logic fill_lo;   // bit entering position 0 on a left move
    logic fill_hi;   // bit entering position MSB on a right move

    always_comb begin
        left = is_left(op);
        unique case (op)
            OP_ROL:  fill_lo = opnd[MSB];
            OP_RCL:  fill_lo = cin;
            default: fill_lo = 1'b0;
        endcase
        unique case (op)
            OP_SAR:  fill_hi = opnd[MSB];
            OP_ROR:  fill_hi = opnd[0];
            OP_RCR:  fill_hi = cin;
            default: fill_hi = 1'b0;
        endcase
        cout = left ? opnd[MSB] : opnd[0];
    end

    // One two-way selector per bit: left neighbour or right neighbour
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_lower;
        logic from_upper;
        if (i == 0) begin : g_lo_edge
            assign from_lower = fill_lo;
        end else begin : g_lo_mid
            assign from_lower = opnd[i-1];
        end
        if (i == MSB) begin : g_hi_edge
            assign from_upper = fill_hi;
        end else begin : g_hi_mid
            assign from_upper = opnd[i+1];
        end
        assign res_next[i] = left ? from_lower : from_upper;
    end

endmodule

// File: rtl/shrot_flag_gen.sv
module shrot_flag_gen
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_op_e      op,
    input  logic [W-1:0]   res_next,
    input  logic           cout,
    input  flags_t         flags_cur,
    output flags_t         flags_next
);
    localparam int MSB = W - 1;

    always_comb begin
        flags_next    = flags_cur;
        flags_next.cf = cout;

        if (op == OP_SAR)
            flags_next.ovf = 1'b0;
        else if (is_left(op))
            flags_next.ovf = res_next[MSB] ^ cout;
        else
            flags_next.ovf = res_next[MSB] ^ res_next[MSB-1];

        if (!is_rotate(op)) begin
            flags_next.zf = (res_next == '0);
            flags_next.sf = res_next[MSB];
            flags_next.pf = even_parity(res_next[PAR_BITS-1:0]);
        end
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [2:0]     op,
    input  logic [W-1:0]   opnd,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cf,
    output logic           zf,
    output logic           sf,
    output logic           pf,
    output logic           ovf
);
    shift_op_e    op_e;
    logic [W-1:0] res_next;
    logic         cout;
    flags_t       flags_q;
    flags_t       flags_d;
    logic [W-1:0] res_q;

    assign op_e = shift_op_e'(op);

    shrot_datapath #(.W(W)) u_dp (
        .op       (op_e),
        .opnd     (opnd),
        .cin      (cin),
        .res_next (res_next),
        .cout     (cout)
    );

    shrot_flag_gen #(.W(W)) u_fg (
        .op         (op_e),
        .res_next   (res_next),
        .cout       (cout),
        .flags_cur  (flags_q),
        .flags_next (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (en) begin
            res_q   <= res_next;
            flags_q <= flags_d;
        end
    end

    assign res = res_q;
    assign cf  = flags_q.cf;
    assign zf  = flags_q.zf;
    assign sf  = flags_q.sf;
    assign pf  = flags_q.pf;
    assign ovf = flags_q.ovf;

endmodule

// File: rtl/shrot_checker.sv
module shrot_checker #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic [2:0]     op,
    input logic [W-1:0]   opnd,
    input logic           cin,
    input logic [W-1:0]   res,
    input logic           cf,
    input logic           zf,
    input logic           sf,
    input logic           pf,
    input logic           ovf
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res == '0) && !cf && !zf && !sf && !pf && !ovf);

    assert_sar_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b011) |=> (res[W-1] == $past(opnd[W-1])) && !ovf);

    assert_rol_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b100) |=> (cf == res[0]));

    assert_ror_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b101) |=> (cf == res[W-1]));

    assert_rcl_in_R6: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b110) |=> (res[0] == $past(cin)));

    assert_shift_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !op[2]) |=> (zf == (res == '0)) && (sf == res[W-1]));

    assert_rotate_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (en && op[2]) |=> $stable(zf) && $stable(sf) && $stable(pf));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(res) && $stable(cf) && $stable(ovf));

endmodule

bind shrot_unit shrot_checker #(.W(W)) u_chk (.*);

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] r;
        logic cf, zf, sf, pf, ovf;
        logic [2:0] op;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [2:0] op = '0;
    logic [W-1:0] opnd = '0;
    logic cin = 1'b0;
    logic [W-1:0] res;
    logic cf, zf, sf, pf, ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic en_d = 1'b0;
    exp_t q[$];
    exp_t model_st;
    exp_t last_item;

    always #10 clk = ~clk;

    shrot_unit #(.W(W)) u_shrot_unit (
        .clk(clk), .rst(rst), .en(en), .op(op), .opnd(opnd), .cin(cin),
        .res(res), .cf(cf), .zf(zf), .sf(sf), .pf(pf), .ovf(ovf)
    );

    always @(posedge clk) en_d <= rst ? 1'b0 : en;

    function automatic exp_t model(input logic [2:0] o, input logic [W-1:0] a,
                                   input logic c, input exp_t prev);
        exp_t e;
        e = prev;
        e.op = o;
        case (o)
            3'd0, 3'd1: begin e.r = {a[W-2:0], 1'b0};   e.cf = a[W-1]; end
            3'd2:       begin e.r = {1'b0, a[W-1:1]};   e.cf = a[0];   end
            3'd3:       begin e.r = {a[W-1], a[W-1:1]}; e.cf = a[0];   end
            3'd4:       begin e.r = {a[W-2:0], a[W-1]}; e.cf = a[W-1]; end
            3'd5:       begin e.r = {a[0], a[W-1:1]};   e.cf = a[0];   end
            3'd6:       begin e.r = {a[W-2:0], c};      e.cf = a[W-1]; end
            default:    begin e.r = {c, a[W-1:1]};      e.cf = a[0];   end
        endcase
        if (o == 3'd3) e.ovf = 1'b0;
        else if (o == 3'd0 || o == 3'd1 || o == 3'd4 || o == 3'd6) e.ovf = e.r[W-1] ^ e.cf;
        else e.ovf = e.r[W-1] ^ e.r[W-2];
        if (o < 3'd4) begin
            e.zf = (e.r == '0);
            e.sf = e.r[W-1];
            e.pf = ~(^e.r[7:0]);
        end
        return e;
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3:       return "R4";
            3'd4, 3'd5: return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: one operation per cycle, expected item pushed to the scoreboard
    task automatic drive(input logic [2:0] o, input logic [W-1:0] a, input logic c);
        @(negedge clk);
        op = o; opnd = a; cin = c; en = 1'b1;
        model_st = model(o, a, c, model_st);
        q.push_back(model_st);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en = 1'b0; op = 3'(i); opnd = 16'hA5C3 ^ 16'(i); cin = ~cin;
        end
    endtask

    // Monitor: compares one cycle after each enabled edge, checks hold otherwise
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (en_d) begin
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected update actual=%h expected=none", res);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(req_of(e.op), "res", res, e.r);
                    check(req_of(e.op), "cf", 16'(cf), 16'(e.cf));
                    check(e.op[2] ? "R8" : "R7", "zf", 16'(zf), 16'(e.zf));
                    check(e.op[2] ? "R8" : "R7", "sf", 16'(sf), 16'(e.sf));
                    check(e.op[2] ? "R8" : "R7", "pf", 16'(pf), 16'(e.pf));
                    check(e.op == 3'd3 ? "R4" : "R9", "ovf", 16'(ovf), 16'(e.ovf));
                    last_item = e;
                end
            end else if (last_item.op !== 3'bx) begin
                check("R10", "hold res", res, last_item.r);
                check("R10", "hold flags", 16'({cf, zf, sf, pf, ovf}),
                      16'({last_item.cf, last_item.zf, last_item.sf, last_item.pf, last_item.ovf}));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lf;
        model_st = '{r: '0, cf: 0, zf: 0, sf: 0, pf: 0, ovf: 0, op: 3'd0};
        last_item = '{r: '0, cf: 0, zf: 0, sf: 0, pf: 0, ovf: 0, op: 3'bx};
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "reset", 16'({res, cf, zf, sf, pf, ovf} != '0), 16'd0);
        rst = 1'b0;

        // R2: top bit out to carry, zero result
        drive(3'd0, 16'h8000, 1'b1);
        drive(3'd1, 16'h4001, 1'b0);
        // R3 / R4
        drive(3'd2, 16'h0001, 1'b0);
        drive(3'd3, 16'h8003, 1'b0);
        drive(3'd3, 16'h7FFE, 1'b1);
        // R8: rotates after a shift keep zf/sf/pf
        drive(3'd4, 16'h8001, 1'b0);
        drive(3'd5, 16'h0001, 1'b0);
        // R6: carry in and carry out in the same cycle
        drive(3'd6, 16'h7FFF, 1'b1);
        drive(3'd6, 16'hFFFF, 1'b1);
        drive(3'd7, 16'hFFFE, 1'b1);
        drive(3'd7, 16'h0001, 1'b1);
        // R10: hold with changing inputs
        idle(4);
        // R7 parity patterns
        drive(3'd2, 16'h0006, 1'b0);
        drive(3'd2, 16'h000E, 1'b0);
        idle(2);
        // Broad sweep over all codes
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(3'(i % 8), lf, lf[3]);
            if (i % 37 == 0) idle(1);
        end
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule